// File: doc/BRIEF.md
# Parallel Flash Command Engine

A synthesizable behavioural model of a byte-wide parallel flash device. The block watches an 18-bit address bus, an 8-bit bidirectional data bus and active-low chip-enable, write-enable and output-enable strobes. It decodes unlock-protected command sequences and runs timed byte-program, sector-erase and whole-chip-erase operations. While an operation runs, it reports progress through two status bits on the data bus instead of a ready pin. An active-low reset input aborts any running operation.

The array is held sparsely. Each of the seven sectors keeps a small window of bytes, selected by the low address bits, so a simulation stays short. Program time, erase time and window size are parameters. A per-sector lock input blocks program and erase on any chosen set of sectors. An erase can be paused to read sectors that are not being erased, and then continued.

Top module: `flash_cmd_engine`

## Requirements
- R1: The sector is chosen from the address: 0x00000–0x0FFFF is sector 0, 0x10000–0x1FFFF is 1, 0x20000–0x2FFFF is 2, 0x30000–0x37FFF is 3, 0x38000–0x39FFF is 4, 0x3A000–0x3BFFF is 5, and 0x3C000–0x3FFFF is 6. Each sector stores 2^SLOT_AW bytes, selected by addr[SLOT_AW-1:0], so addresses in one sector that share those bits alias to the same byte.
- R2: A bus write is taken only in the first clock cycle where ce_n=0, we_n=0 and oe_n=1. That cycle latches both address and data. A write strobe with ce_n high has no effect.
- R3: After reset every stored byte reads 0xFF and the machine is in read mode. In read mode, a read (ce_n=0, oe_n=0) returns the stored byte.
- R4: The sequence 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555 arms a program. The next write gives the address and data, and the byte becomes the old byte AND the new data. Command addresses are compared on addr[10:0].
- R5: A program takes PGM_CYC clock edges after its data write. While it runs, any read returns bit 7 equal to the inverse of data bit 7, bit 6 flipping at each new read, and bits 5:0 zero. When it ends, the machine returns to read mode.
- R6: The sequence 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 at any address of a sector, erases that sector to 0xFF after ERS_CYC edges. No other sector changes. While the erase runs, reads return status with bit 7 at 0.
- R7: The same five-write prefix followed by 0x10@0x555 erases every unlocked sector. Locked sectors keep their data.
- R8: A program or sector erase aimed at a sector whose sect_lock bit is 1 is dropped. The machine goes straight back to read mode and the data is kept.
- R9: Writing 0xB0 during an erase suspends it. During suspend, reads of sectors not being erased return data, and reads of sectors being erased return bit 7 at 0 with bits 5:0 zero. The erase timer is held. Writing 0x30 resumes the erase, which then completes.
- R10: A write that breaks a command sequence, including 0xF0, returns the machine to read mode without any program or erase.
- R11: Driving rst_n low aborts a running program or erase and returns the machine to read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; aborts operations, clears the array to 0xFF |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W (18) | Byte address |
| dq | inout | 8 | Data bus; driven only while ce_n and oe_n are both low |
| sect_lock | input | 7 | Per-sector protection, bit n guards sector n |

## Verification
A bus write acts on the clock edge where the write strobe is first seen. A read's toggle bit is updated on the edge where the read begins. A program result appears PGM_CYC edges after the data-write edge, and an erase result ERS_CYC edges after its final command edge, plus any edges spent in suspend. The bench's behavioural model steps on every rising edge from the same sampled pins, and the bench compares the data bus with the model on every falling edge while a read is open. Directed checks sample reads only after one rising edge has seen the read, and wait for completion with a margin of several cycles beyond the parameterized durations.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
    localparam int NUM_SECT = 7;
    localparam int SECT_W   = 3;
    localparam int CMD_AW   = 11;

    typedef enum logic [3:0] {
        ST_READ, ST_UNL1, ST_UNL2, ST_PGM_ARM,
        ST_ERS_1, ST_ERS_2, ST_ERS_3,
        ST_PGM_RUN, ST_ERS_RUN, ST_ERS_SUSP
    } fsm_e;

    localparam logic [CMD_AW-1:0] CMD_A1 = 11'h555;
    localparam logic [CMD_AW-1:0] CMD_A2 = 11'h2AA;
    localparam logic [7:0] K_UNL1  = 8'hAA;
    localparam logic [7:0] K_UNL2  = 8'h55;
    localparam logic [7:0] K_PGM   = 8'hA0;
    localparam logic [7:0] K_ERS   = 8'h80;
    localparam logic [7:0] K_SECT  = 8'h30;
    localparam logic [7:0] K_CHIP  = 8'h10;
    localparam logic [7:0] K_SUSP  = 8'hB0;
    localparam logic [7:0] K_RESUM = 8'h30;
endpackage

// File: rtl/flash_sector_map.sv
module flash_sector_map
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SECT_W-1:0] sect
);
    // 2K-byte units: 64K = 32 units, 32K = 16, 8K = 4, 16K = 8
    logic [6:0] unit;

    always_comb begin
        unit = addr[ADDR_W-1 -: 7];
        if (unit < 7'd96)       sect = {1'b0, unit[6:5]};
        else if (unit < 7'd112) sect = 3'd3;
        else if (unit < 7'd116) sect = 3'd4;
        else if (unit < 7'd120) sect = 3'd5;
        else                    sect = 3'd6;
    end
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
    import flash_cmd_pkg::*;
#(
    parameter int SLOT_AW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SECT_W-1:0]   rd_sect,
    input  logic [SLOT_AW-1:0]  rd_slot,
    output logic [7:0]          rd_byte,
    input  logic                pgm_en,
    input  logic [SECT_W-1:0]   pgm_sect,
    input  logic [SLOT_AW-1:0]  pgm_slot,
    input  logic [7:0]          pgm_byte,
    input  logic                ers_en,
    input  logic [NUM_SECT-1:0] ers_mask
);
    localparam int SLOTS = 1 << SLOT_AW;
    localparam int DEPTH = NUM_SECT * SLOTS;
    localparam int IDX_W = SECT_W + SLOT_AW;

    logic [7:0]       cell_q [DEPTH];
    logic [7:0]       cell_d [DEPTH];
    logic [IDX_W-1:0] p_idx;
    logic [IDX_W-1:0] r_idx;

    assign p_idx   = {pgm_sect, pgm_slot};
    assign r_idx   = {rd_sect, rd_slot};
    assign rd_byte = cell_q[r_idx];

    always_comb begin
        for (int s = 0; s < NUM_SECT; s++) begin
            for (int k = 0; k < SLOTS; k++) begin
                cell_d[s*SLOTS+k] = (ers_en && ers_mask[s]) ? 8'hFF : cell_q[s*SLOTS+k];
            end
        end
        if (pgm_en) cell_d[p_idx] = cell_q[p_idx] & pgm_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= 8'hFF;
        end else begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= cell_d[i];
        end
    end

    // R4
    prog_clears_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_en |=> cell_q[$past(p_idx)] == ($past(cell_q[p_idx]) & $past(pgm_byte)));
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int SLOT_AW = 4,
    parameter int PGM_CYC = 16,
    parameter int ERS_CYC = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic [ADDR_W-1:0]   addr,
    inout  wire  [7:0]          dq,
    input  logic [NUM_SECT-1:0] sect_lock
);
    localparam int MAX_CYC = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        fsm_e                st;
        logic [CNT_W-1:0]    cnt;
        logic                wr_prev;
        logic                rd_prev;
        logic                tog;
        logic [SECT_W-1:0]   t_sect;
        logic [SLOT_AW-1:0]  t_slot;
        logic [7:0]          t_byte;
        logic [NUM_SECT-1:0] e_mask;
    } regs_t;

    regs_t reg_q, reg_d;

    logic                wr_on, rd_on, wr_ev, rd_ev, running;
    logic                pgm_en, ers_en;
    logic [SECT_W-1:0]   a_sect;
    logic [7:0]          din, arr_byte, rd_val;
    logic [CMD_AW-1:0]   a_cmd;
    logic [NUM_SECT-1:0] new_mask;

    flash_sector_map #(.ADDR_W(ADDR_W)) u_map (
        .addr (addr),
        .sect (a_sect)
    );

    flash_cell_array #(.SLOT_AW(SLOT_AW)) u_cells (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sect  (a_sect),
        .rd_slot  (addr[SLOT_AW-1:0]),
        .rd_byte  (arr_byte),
        .pgm_en   (pgm_en),
        .pgm_sect (reg_q.t_sect),
        .pgm_slot (reg_q.t_slot),
        .pgm_byte (reg_q.t_byte),
        .ers_en   (ers_en),
        .ers_mask (reg_q.e_mask)
    );

    assign wr_on   = !ce_n && !we_n && oe_n;
    assign rd_on   = !ce_n && !oe_n;
    assign wr_ev   = wr_on && !reg_q.wr_prev;
    assign rd_ev   = rd_on && !reg_q.rd_prev;
    assign running = (reg_q.st == ST_PGM_RUN) || (reg_q.st == ST_ERS_RUN);
    assign din     = dq;
    assign a_cmd   = addr[CMD_AW-1:0];

    always_comb begin
        reg_d         = reg_q;
        reg_d.wr_prev = wr_on;
        reg_d.rd_prev = rd_on;
        pgm_en        = 1'b0;
        ers_en        = 1'b0;
        new_mask      = '0;
        if (running && rd_ev) reg_d.tog = ~reg_q.tog;

        unique case (reg_q.st)
            ST_READ: if (wr_ev && din == K_UNL1 && a_cmd == CMD_A1) reg_d.st = ST_UNL1;
            ST_UNL1: if (wr_ev) reg_d.st = (din == K_UNL2 && a_cmd == CMD_A2) ? ST_UNL2 : ST_READ;
            ST_UNL2: if (wr_ev) begin
                if (din == K_PGM && a_cmd == CMD_A1)      reg_d.st = ST_PGM_ARM;
                else if (din == K_ERS && a_cmd == CMD_A1) reg_d.st = ST_ERS_1;
                else                                      reg_d.st = ST_READ;
            end
            ST_PGM_ARM: if (wr_ev) begin
                reg_d.t_sect = a_sect;
                reg_d.t_slot = addr[SLOT_AW-1:0];
                reg_d.t_byte = din;
                reg_d.cnt    = CNT_W'(PGM_CYC - 1);
                reg_d.st     = sect_lock[a_sect] ? ST_READ : ST_PGM_RUN;
            end
            ST_ERS_1: if (wr_ev) reg_d.st = (din == K_UNL1 && a_cmd == CMD_A1) ? ST_ERS_2 : ST_READ;
            ST_ERS_2: if (wr_ev) reg_d.st = (din == K_UNL2 && a_cmd == CMD_A2) ? ST_ERS_3 : ST_READ;
            ST_ERS_3: if (wr_ev) begin
                if (din == K_SECT)                         new_mask = (NUM_SECT'(1) << a_sect) & ~sect_lock;
                else if (din == K_CHIP && a_cmd == CMD_A1) new_mask = ~sect_lock;
                reg_d.e_mask = new_mask;
                reg_d.cnt    = CNT_W'(ERS_CYC - 1);
                reg_d.st     = (new_mask != '0) ? ST_ERS_RUN : ST_READ;
            end
            ST_PGM_RUN: begin
                if (reg_q.cnt == '0) begin
                    pgm_en   = 1'b1;
                    reg_d.st = ST_READ;
                end else reg_d.cnt = reg_q.cnt - 1'b1;
            end
            ST_ERS_RUN: begin
                if (wr_ev && din == K_SUSP) reg_d.st = ST_ERS_SUSP;
                else if (reg_q.cnt == '0) begin
                    ers_en       = 1'b1;
                    reg_d.e_mask = '0;
                    reg_d.st     = ST_READ;
                end else reg_d.cnt = reg_q.cnt - 1'b1;
            end
            ST_ERS_SUSP: if (wr_ev && din == K_RESUM) reg_d.st = ST_ERS_RUN;
            default: reg_d.st = ST_READ;
        endcase
    end

    always_comb begin
        if (reg_q.st == ST_PGM_RUN)
            rd_val = {~reg_q.t_byte[7], reg_q.tog, 6'b0};
        else if (reg_q.st == ST_ERS_RUN)
            rd_val = {1'b0, reg_q.tog, 6'b0};
        else if (reg_q.st == ST_ERS_SUSP && reg_q.e_mask[a_sect])
            rd_val = {1'b0, reg_q.tog, 6'b0};
        else
            rd_val = arr_byte;
    end

    assign dq = rd_on ? rd_val : 8'hzz;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    // R8
    lock_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q.st == ST_PGM_ARM && wr_ev && sect_lock[a_sect]) |=> reg_q.st == ST_READ);
    // R9
    susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q.st == ST_ERS_SUSP) |=> $stable(reg_q.cnt));
    // R5
    tog_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> $stable(reg_q.tog));
    // R5
    auto_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q.st == ST_PGM_RUN && reg_q.cnt == '0) |=> reg_q.st == ST_READ);
    // R6
    erase_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ers_en |=> (reg_q.st == ST_READ && reg_q.e_mask == '0));
endmodule

// File: tb/tb_flash_cmd_engine.sv
`timescale 1ns/1ps
module tb_flash_cmd_engine;
    localparam int SLOT_AW = 4;
    localparam int SLOTS   = 1 << SLOT_AW;
    localparam int NB      = 7 * SLOTS;
    localparam int PGM_CYC = 16;
    localparam int ERS_CYC = 64;

    logic clk = 1'b0;
    logic rst_n, ce_n, we_n, oe_n, tb_drv, mon_on;
    logic [17:0] addr;
    logic [7:0]  tb_d;
    logic [6:0]  sect_lock;
    wire  [7:0]  dq;
    int total = 0;
    int bad = 0;
    bit finished = 0;
    string cur_req = "R3";

    assign dq = tb_drv ? tb_d : 8'hzz;
    always #2.5 clk = ~clk;

    flash_cmd_engine #(.ADDR_W(18), .SLOT_AW(SLOT_AW), .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq(dq), .sect_lock(sect_lock)
    );

    // behavioural reference model
    int m_st, m_cnt, m_tsl;
    bit m_wrp, m_rdp, m_tog;
    logic [7:0] m_mem [NB];
    logic [7:0] m_tb;
    logic [6:0] m_em;
    bit w_on, r_on, w_e, r_e;
    int w_sec;
    logic [10:0] w_a;

    function automatic int sect_of(logic [17:0] a);
        if (a < 18'h10000) return 0;
        if (a < 18'h20000) return 1;
        if (a < 18'h30000) return 2;
        if (a < 18'h38000) return 3;
        if (a < 18'h3A000) return 4;
        if (a < 18'h3C000) return 5;
        return 6;
    endfunction

    function automatic logic [7:0] m_out(logic [17:0] a);
        if (m_st == 7) return {~m_tb[7], m_tog, 6'b0};
        if (m_st == 8) return {1'b0, m_tog, 6'b0};
        if (m_st == 9 && m_em[sect_of(a)]) return {1'b0, m_tog, 6'b0};
        return m_mem[sect_of(a) * SLOTS + int'(a) % SLOTS];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_wrp = 0; m_rdp = 0; m_tog = 0; m_em = 0;
            for (int i = 0; i < NB; i++) m_mem[i] = 8'hFF;
        end else begin
            w_on = !ce_n && !we_n && oe_n;
            r_on = !ce_n && !oe_n;
            w_e = w_on && !m_wrp;
            r_e = r_on && !m_rdp;
            m_wrp = w_on; m_rdp = r_on;
            w_sec = sect_of(addr);
            w_a = addr[10:0];
            if ((m_st == 7 || m_st == 8) && r_e) m_tog = !m_tog;
            case (m_st)
                0: if (w_e && tb_d == 8'hAA && w_a == 11'h555) m_st = 1;
                1: if (w_e) m_st = (tb_d == 8'h55 && w_a == 11'h2AA) ? 2 : 0;
                2: if (w_e) m_st = (tb_d == 8'hA0 && w_a == 11'h555) ? 3 :
                                   (tb_d == 8'h80 && w_a == 11'h555) ? 4 : 0;
                3: if (w_e) begin
                    m_tsl = w_sec * SLOTS + int'(addr) % SLOTS;
                    m_tb = tb_d; m_cnt = PGM_CYC - 1;
                    m_st = sect_lock[w_sec] ? 0 : 7;
                end
                4: if (w_e) m_st = (tb_d == 8'hAA && w_a == 11'h555) ? 5 : 0;
                5: if (w_e) m_st = (tb_d == 8'h55 && w_a == 11'h2AA) ? 6 : 0;
                6: if (w_e) begin
                    if (tb_d == 8'h30) m_em = (7'd1 << w_sec) & ~sect_lock;
                    else if (tb_d == 8'h10 && w_a == 11'h555) m_em = ~sect_lock;
                    else m_em = 0;
                    m_cnt = ERS_CYC - 1;
                    m_st = (m_em != 0) ? 8 : 0;
                end
                7: if (m_cnt == 0) begin m_mem[m_tsl] = m_mem[m_tsl] & m_tb; m_st = 0; end
                   else m_cnt--;
                8: if (w_e && tb_d == 8'hB0) m_st = 9;
                   else if (m_cnt == 0) begin
                       for (int i = 0; i < NB; i++) if (m_em[i / SLOTS]) m_mem[i] = 8'hFF;
                       m_em = 0; m_st = 0;
                   end else m_cnt--;
                9: if (w_e && tb_d == 8'h30) m_st = 8;
                default: m_st = 0;
            endcase
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    // compare bus against model on every cycle with an open read
    always @(negedge clk) begin
        if (mon_on && rst_n && !ce_n && !oe_n) chk(cur_req, dq, m_out(addr));
    end

    task automatic wr(input logic [17:0] a, input logic [7:0] v);
        @(posedge clk); #1; addr = a; tb_d = v; tb_drv = 1; ce_n = 0; we_n = 0;
        @(posedge clk); #1; we_n = 1; ce_n = 1;
        @(posedge clk); #1; tb_drv = 0;
    endtask

    task automatic wr_noce(input logic [17:0] a, input logic [7:0] v);
        @(posedge clk); #1; addr = a; tb_d = v; tb_drv = 1; ce_n = 1; we_n = 0;
        @(posedge clk); #1; we_n = 1;
        @(posedge clk); #1; tb_drv = 0;
    endtask

    task automatic rd(input logic [17:0] a, output logic [7:0] v);
        @(posedge clk); #1; addr = a; ce_n = 0; oe_n = 0;
        @(posedge clk); @(negedge clk); v = dq;
        @(posedge clk); #1; ce_n = 1; oe_n = 1;
    endtask

    task automatic pgm(input logic [17:0] a, input logic [7:0] v);
        wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h55); wr(18'h00555, 8'hA0); wr(a, v);
    endtask

    task automatic ers_prefix();
        wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h55); wr(18'h00555, 8'h80);
        wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h55);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R5 watchdog actual=hung expected=complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, r1, r2;
        ce_n = 1; we_n = 1; oe_n = 1; addr = '0; tb_d = '0; tb_drv = 0;
        sect_lock = '0; rst_n = 0; mon_on = 0;
        idle(3); #1 rst_n = 1; mon_on = 1;

        cur_req = "R3";
        rd(18'h00000, v); chk("R3", v, 8'hFF);
        rd(18'h3FFFF, v); chk("R3", v, 8'hFF);

        cur_req = "R5";
        pgm(18'h00123, 8'hA5);
        rd(18'h00123, r1); rd(18'h05555, r2);
        chk("R5", r1 & 8'hBF, 8'h00);
        chk("R5", (r1 ^ r2) & 8'h40, 8'h40);
        idle(PGM_CYC + 4);
        rd(18'h00123, v); chk("R5", v, 8'hA5);

        cur_req = "R4";
        pgm(18'h00123, 8'h3C); idle(PGM_CYC + 4);
        rd(18'h00123, v); chk("R4", v, 8'h24);

        cur_req = "R1";
        rd(18'h00133, v); chk("R1", v, 8'h24);
        pgm(18'h10003, 8'h11); idle(PGM_CYC + 4);
        rd(18'h10003, v); chk("R1", v, 8'h11);
        rd(18'h00003, v); chk("R1", v, 8'h24);

        cur_req = "R2";
        wr_noce(18'h00555, 8'hAA); wr_noce(18'h002AA, 8'h55);
        wr_noce(18'h00555, 8'hA0); wr_noce(18'h20007, 8'h00);
        idle(PGM_CYC + 4);
        rd(18'h20007, v); chk("R2", v, 8'hFF);

        cur_req = "R10";
        wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h12); wr(18'h00555, 8'hA0); wr(18'h20008, 8'h00);
        idle(PGM_CYC + 4);
        rd(18'h20008, v); chk("R10", v, 8'hFF);
        wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h55); wr(18'h00555, 8'hF0);
        wr(18'h00555, 8'hA0); wr(18'h20009, 8'h00);
        idle(PGM_CYC + 4);
        rd(18'h20009, v); chk("R10", v, 8'hFF);

        cur_req = "R6";
        pgm(18'h37FFF, 8'h5A); idle(PGM_CYC + 4);
        pgm(18'h38001, 8'h12); idle(PGM_CYC + 4);
        pgm(18'h3A001, 8'h34); idle(PGM_CYC + 4);
        ers_prefix(); wr(18'h39FFF, 8'h30);
        rd(18'h3A001, v); chk("R6", v & 8'hBF, 8'h00);
        idle(ERS_CYC + 8);
        rd(18'h37FFF, v); chk("R6", v, 8'h5A);
        rd(18'h38001, v); chk("R6", v, 8'hFF);
        rd(18'h3A001, v); chk("R1", v, 8'h34);

        cur_req = "R8";
        pgm(18'h3C010, 8'hF0); idle(PGM_CYC + 4);
        sect_lock = 7'b1000000;
        pgm(18'h3C010, 8'h0F);
        rd(18'h3C010, v); chk("R8", v, 8'hF0);
        idle(PGM_CYC + 4);
        rd(18'h3C010, v); chk("R8", v, 8'hF0);
        ers_prefix(); wr(18'h3C000, 8'h30);
        rd(18'h3C010, v); chk("R8", v, 8'hF0);
        idle(ERS_CYC + 8);
        rd(18'h3C010, v); chk("R8", v, 8'hF0);

        cur_req = "R9";
        sect_lock = '0;
        pgm(18'h00200, 8'h00); idle(PGM_CYC + 4);
        ers_prefix(); wr(18'h00000, 8'h30);
        idle(4); wr(18'h00000, 8'hB0);
        rd(18'h10003, v); chk("R9", v, 8'h11);
        rd(18'h00200, v); chk("R9", v & 8'hBF, 8'h00);
        idle(ERS_CYC + 30);
        rd(18'h00200, v); chk("R9", v & 8'hBF, 8'h00);
        wr(18'h00000, 8'h30);
        idle(ERS_CYC + 8);
        rd(18'h00200, v); chk("R9", v, 8'hFF);
        rd(18'h00123, v); chk("R9", v, 8'hFF);
        rd(18'h10003, v); chk("R9", v, 8'h11);

        cur_req = "R7";
        sect_lock = 7'b0000010;
        ers_prefix(); wr(18'h00555, 8'h10);
        idle(ERS_CYC + 8);
        rd(18'h10003, v); chk("R7", v, 8'h11);
        rd(18'h3C010, v); chk("R7", v, 8'hFF);
        rd(18'h37FFF, v); chk("R7", v, 8'hFF);

        cur_req = "R11";
        sect_lock = '0;
        pgm(18'h20020, 8'h00); idle(3);
        @(posedge clk); #1 rst_n = 0;
        idle(2); #1 rst_n = 1;
        rd(18'h20020, v); chk("R11", v, 8'hFF);
        rd(18'h20020, v); chk("R11", v, 8'hFF);
        idle(PGM_CYC + 4);
        rd(18'h20020, v); chk("R11", v, 8'hFF);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule